// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches a bank of general-purpose input pins, grouped in ports of eight, and turns selected pin activity into latched interrupt status. Every pin carries its own trigger choice: a rising edge, a falling edge, either edge, a high level or a low level. When a pin's condition is seen, its status bit is set and stays set until software writes a one to the matching clear bit. The pin values arrive already synchronised to the block clock.

Each port drives its own interrupt line, which is high whenever one of its status bits is set and enabled. The bank request is the OR of all port lines. Enables only gate the request lines; they never stop status from latching. Edge-type pins are meant to be cleared before they are serviced, so an edge that lands while the clear is being written is kept, not lost. Level-type pins keep setting their status for as long as their level lasts, so clearing one while the level is still present does not remove it.

Top module: `irqd_bank`

## Requirements
- R1: For pin n (0..7) of port p, the trigger field sits in the 24-bit lane `trig_cfg[p*24 +: 24]`: bit n is the polarity (1 = high/rising), bit n+8 selects edge mode (1) over level mode (0), and bit n+16 selects both edges when edge mode is on.
- R2: With code 0x000101 shifted left by n (rising), a 0-to-1 change of the pin sets its status bit at the next clock edge; a 1-to-0 change does not.
- R3: With code 0x000100 shifted left by n (falling), a 1-to-0 change sets the status bit; a 0-to-1 change does not.
- R4: With code 0x010100 shifted left by n (both edges), either change sets the status bit.
- R5: With code 0x000001 shifted left by n (high level), the status bit is set on every clock edge at which the pin is 1, so a clear while the pin is still 1 leaves it set.
- R6: With code 0x000000 (low level), the status bit is set on every clock edge at which the pin is 0.
- R7: A set status bit stays set until a clock edge at which its bit in `clr_pulse` is 1; a 0 in `clr_pulse` has no effect on it.
- R8: If an edge event and a clear of the same bit arrive at the same clock edge, the status bit stays set.
- R9: `port_irq[p]` is 1 exactly when some status bit of port p has its enable bit set; `bank_irq` is the OR of all `port_irq` bits; enables do not affect the status bits.
- R10: The previous pin value used for edge detection is updated on every clock regardless of trigger type, and is loaded with the pin value during reset, so neither a type change nor reset release creates an edge that did not happen.
- R11: While `rst` is high at a clock edge, all status bits are cleared and no interrupt is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPORTS*PINS | Synchronised pin values, pin index p*PINS+n |
| trig_cfg | input | NPORTS*3*PINS | Per-port trigger lanes (polarity, edge, both) |
| irq_en | input | NPORTS*PINS | Per-pin interrupt enable |
| clr_pulse | input | NPORTS*PINS | Write-one-to-clear pulses, one cycle each |
| status | output | NPORTS*PINS | Latched interrupt status per pin |
| port_irq | output | NPORTS | Per-port request: status AND enable, ORed over the port |
| bank_irq | output | 1 | OR of all port requests |

## Verification
On every cycle the assertions check that a status bit only falls after a clear, that an uncleared bit holds, that an active level keeps its bit set, that a single edge beats a simultaneous clear, and that a port with no enables stays quiet. The choice of which edge direction counts for each encoding, the exact placement of the three trigger bits in their lanes, the absence of a false edge after reset or after a type change, and the independence of enables from latching can only be shown by the bench's directed scenarios, which drive each trigger type on different pins and ports and compare the status word against expected values.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    // Decoded trigger choice for one pin.
    typedef struct packed {
        logic both_md;   // either edge counts (edge mode only)
        logic edge_md;   // 1: edge detect, 0: level detect
        logic high_md;   // polarity: rising edge / high level
    } pin_trig_t;

    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'd0,
        SENSE_ONE   = 2'd1,
        SENSE_TWO   = 2'd2
    } sense_e;

    function automatic sense_e sense_of(pin_trig_t t);
        if (!t.edge_md)    return SENSE_LEVEL;
        else if (t.both_md) return SENSE_TWO;
        else               return SENSE_ONE;
    endfunction

    // Event for one pin given its trigger and the current/previous samples.
    function automatic logic pin_event(pin_trig_t t, logic cur, logic prv);
        logic rise;
        logic fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        unique case (sense_of(t))
            SENSE_LEVEL: return t.high_md ? cur : ~cur;
            SENSE_ONE:   return t.high_md ? rise : fall;
            SENSE_TWO:   return rise | fall;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irqd_lane_decode.sv
module irqd_lane_decode
    import irqd_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic [3*PINS-1:0]           lane,
    output pin_trig_t [PINS-1:0]        trig
);
    localparam int EDGE_BASE = PINS;
    localparam int BOTH_BASE = 2 * PINS;

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        assign trig[n].high_md = lane[n];
        assign trig[n].edge_md = lane[EDGE_BASE + n];
        assign trig[n].both_md = lane[BOTH_BASE + n];
    end

endmodule

// File: rtl/irqd_port.sv
module irqd_port
    import irqd_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PINS-1:0]       pin_now,
    input  pin_trig_t [PINS-1:0]  trig,
    input  logic [PINS-1:0]       en,
    input  logic [PINS-1:0]       clr,
    output logic [PINS-1:0]       status,
    output logic                  irq
);
    logic [PINS-1:0] pin_prev;
    logic [PINS-1:0] hit;

    for (genvar n = 0; n < PINS; n++) begin : g_evt
        assign hit[n] = pin_event(trig[n], pin_now[n], pin_prev[n]);
    end

    // Previous sample follows the pin every cycle, independent of type.
    always_ff @(posedge clk) begin
        pin_prev <= pin_now;
    end

    // New events win over a clear arriving in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr) | hit;
    end

    assign irq = |(status & en);

    for (genvar n = 0; n < PINS; n++) begin : g_chk
        AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (status[n] && !clr[n]) |=> status[n]); // R7
        AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
            $fell(status[n]) |-> $past(clr[n])); // R7
        AST_LEVEL_HIGH_SETS: assert property (@(posedge clk) disable iff (rst)
            (!trig[n].edge_md && trig[n].high_md && pin_now[n]) |=> status[n]); // R5
        AST_LEVEL_LOW_SETS: assert property (@(posedge clk) disable iff (rst)
            (!trig[n].edge_md && !trig[n].high_md && !pin_now[n]) |=> status[n]); // R6
        AST_RISE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (trig[n].edge_md && !trig[n].both_md && trig[n].high_md
             && pin_now[n] && !$past(pin_now[n]) && clr[n]) |=> status[n]); // R8
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq); // R9

endmodule

// File: rtl/irqd_bank.sv
module irqd_bank
    import irqd_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int PINS   = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NPORTS*PINS-1:0]      pin_in,
    input  logic [NPORTS*3*PINS-1:0]    trig_cfg,
    input  logic [NPORTS*PINS-1:0]      irq_en,
    input  logic [NPORTS*PINS-1:0]      clr_pulse,
    output logic [NPORTS*PINS-1:0]      status,
    output logic [NPORTS-1:0]           port_irq,
    output logic                        bank_irq
);
    localparam int LANE_W = 3 * PINS;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        pin_trig_t [PINS-1:0] trig;

        irqd_lane_decode #(.PINS(PINS)) u_dec (
            .lane (trig_cfg[p*LANE_W +: LANE_W]),
            .trig (trig)
        );

        irqd_port #(.PINS(PINS)) u_port (
            .clk     (clk),
            .rst     (rst),
            .pin_now (pin_in[p*PINS +: PINS]),
            .trig    (trig),
            .en      (irq_en[p*PINS +: PINS]),
            .clr     (clr_pulse[p*PINS +: PINS]),
            .status  (status[p*PINS +: PINS]),
            .irq     (port_irq[p])
        );
    end

    assign bank_irq = |port_irq;

    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (port_irq == '0) |-> !bank_irq); // R9

endmodule

// File: tb/irqd_bank_tb_top.sv
`timescale 1ns/1ps
module irqd_bank_tb_top;
    localparam int NP = 4;
    localparam int PN = 8;
    localparam int W  = NP * PN;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0]   pin_in = '0;
    logic [3*W-1:0] trig_cfg = '0;
    logic [W-1:0]   irq_en = '0;
    logic [W-1:0]   clr_pulse = '0;
    logic [W-1:0]   status;
    logic [NP-1:0]  port_irq;
    logic           bank_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irqd_bank #(.NPORTS(NP), .PINS(PN)) dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in), .trig_cfg(trig_cfg),
        .irq_en(irq_en), .clr_pulse(clr_pulse), .status(status),
        .port_irq(port_irq), .bank_irq(bank_irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // kind: {both, edge, high}
    task automatic set_type(int idx, logic [2:0] kind);
        int p = idx / PN;
        int n = idx % PN;
        trig_cfg[p*3*PN + n]        = kind[0];
        trig_cfg[p*3*PN + PN + n]   = kind[1];
        trig_cfg[p*3*PN + 2*PN + n] = kind[2];
    endtask

    task automatic clear_all();
        clr_pulse = '1; tick(); clr_pulse = '0;
    endtask

    task automatic t_reset();
        for (int p = 0; p < NP; p++) trig_cfg[p*3*PN +: 3*PN] = {8'h00, 8'hFF, 8'hFF};
        pin_in[9] = 1'b1;
        repeat (3) tick();
        chk("R11 status in reset", status, 0);
        chk("R11 bank_irq in reset", bank_irq, 0);
        rst = 1'b0; tick();
        chk("R10 no edge at reset release", status, 0);
        pin_in[9] = 1'b0; tick();
        chk("R2 falling ignored by rising", status, 0);
    endtask

    task automatic t_rising();
        pin_in[11] = 1'b1; tick();
        chk("R2 rising sets", status, 64'h1 << 11);
        clr_pulse[11] = 1'b1; tick(); clr_pulse = '0;
        chk("R7 clear one", status, 0);
        pin_in[11] = 1'b0; tick();
        chk("R2 fall ignored", status, 0);
    endtask

    task automatic t_falling();
        set_type(11, 3'b010); tick();
        pin_in[11] = 1'b1; tick();
        chk("R3 rise ignored", status, 0);
        pin_in[11] = 1'b0; tick();
        chk("R3 falling sets (R1 lane 1)", status, 64'h1 << 11);
        clear_all();
        set_type(11, 3'b011);
    endtask

    task automatic t_both();
        set_type(21, 3'b110); tick();
        pin_in[21] = 1'b1; tick();
        chk("R4 both rise", status, 64'h1 << 21);
        clear_all();
        chk("R4 cleared", status, 0);
        pin_in[21] = 1'b0; tick();
        chk("R4 both fall", status, 64'h1 << 21);
        clear_all();
        set_type(21, 3'b011);
    endtask

    task automatic t_level_high();
        set_type(7, 3'b001); tick();
        chk("R5 idle low", status, 0);
        pin_in[7] = 1'b1; tick();
        chk("R5 high sets", status, 64'h80);
        clr_pulse[7] = 1'b1; tick(); clr_pulse = '0;
        chk("R5 reasserts while high", status, 64'h80);
        pin_in[7] = 1'b0; clr_pulse[7] = 1'b1; tick(); clr_pulse = '0;
        chk("R5 clear after drop", status, 0);
        set_type(7, 3'b011);
    endtask

    task automatic t_level_low();
        set_type(24, 3'b000); tick();
        chk("R6 low sets", status, 64'h1 << 24);
        pin_in[24] = 1'b1; clr_pulse[24] = 1'b1; tick(); clr_pulse = '0;
        chk("R6 clear when high", status, 0);
        set_type(24, 3'b011); tick();
        pin_in[24] = 1'b0; tick();
    endtask

    task automatic t_edge_wins();
        pin_in[4] = 1'b1; clr_pulse[4] = 1'b1; tick(); clr_pulse = '0;
        chk("R8 edge beats clear", status, 64'h10);
        clr_pulse = ~(64'h10); tick(); clr_pulse = '0;
        chk("R7 zero in clear keeps", status, 64'h10);
    endtask

    task automatic t_enable();
        #1;
        chk("R9 no enables", {bank_irq, port_irq}, 5'b00000);
        irq_en = 32'h10; #1;
        chk("R9 enabled pin", {bank_irq, port_irq}, 5'b10001);
        irq_en = ~32'h10; #1;
        chk("R9 other enables", {bank_irq, port_irq}, 5'b00000);
        tick();
        chk("R9 enable leaves status", status, 64'h10);
        irq_en = '0;
        clear_all();
        pin_in[4] = 1'b0; tick();
    endtask

    task automatic t_type_change();
        set_type(6, 3'b000); tick();
        pin_in[6] = 1'b1; tick(); tick();
        clear_all();
        chk("R10 level low cleared", status, 0);
        set_type(6, 3'b011); tick();
        chk("R10 no edge on type change", status, 0);
        pin_in[6] = 1'b0; tick();
        pin_in[6] = 1'b1; tick();
        chk("R1 lane 0 rising after change", status, 64'h40);
        clear_all();
    endtask

    initial begin
        t_reset();
        t_rising();
        t_falling();
        t_both();
        t_level_high();
        t_level_low();
        t_edge_wins();
        t_enable();
        t_type_change();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule